// File: doc/BRIEF.md
# Audio sample FIFO pair with attention threshold

This block buffers audio samples between a 32-bit bus-side word port and a serial audio engine. It holds two independent queues of sixteen words each. The transmit queue takes words written from the bus and hands samples to the engine one request at a time. The receive queue takes samples from the engine and offers complete words to the bus. Each queue has a two-bit attention level. When the free space (transmit) or the filled space (receive) reaches that level, the queue raises a ready flag. A per-queue enable turns the ready flag into a service request for a DMA engine or an interrupt controller.

Each queue also reports an occupancy count, a busy flag and a sticky error flag. The transmit error is set by underflow and the receive error by overflow. A per-queue error-interrupt enable drives an error interrupt output. A single-cycle clear pulse empties a queue. A three-bit format selector decides how engine samples relate to bus words. In the LSB-aligned modes, bits above the sample width are forced to zero. In the paired mode, two 16-bit samples share one bus word, with left in the low half and right in the high half.

Top module: `audio_sample_fifo_pair`

## Requirements
- R1: The transmit queue stores 16 words in arrival order. A bus write is accepted when the queue is not full, and a write to a full queue is dropped. `txFree` reports the free slots, from 16 when empty down to 0.
- R2: `busRdData` shows the oldest receive word, and `busRdReq` removes it. `rxFill` reports the filled slots, from 0 to 16. A read of an empty receive queue returns zero and changes nothing.
- R3: Attention-level code 0 means 1 slot, 1 means 4 slots, 2 means 8 slots and 3 means 12 slots. `txReady` is high when the free slots are at or above the level. `rxReady` is high when the filled slots are at or above the level.
- R4: Each service request equals its ready flag ANDed with its request enable. Each error interrupt equals its error flag ANDed with its error-interrupt enable.
- R5: An engine request on an empty transmit queue sets `txErr` on the next cycle, and `engTxSample` reads zero during that request.
- R6: A completed receive word that arrives while the receive queue holds 16 words is dropped, `rxErr` is set, and the stored contents are unchanged.
- R7: An error flag stays set until its error-clear pulse. If a new error and the clear arrive in the same cycle, the flag stays set.
- R8: A clear pulse empties its queue by the next cycle and restarts the paired-mode half sequence. It leaves the error flag as it was.
- R9: Format codes 0, 1 and 2 keep the low 16, 20 and 24 bits, and code 3 keeps all 32 bits. Codes 4 to 6 act as code 3. Transmit samples are the head word with the upper bits zeroed. Receive words are the sample with the upper bits zeroed.
- R10: Format code 7 is the paired mode. A transmit word yields bits 15:0 on the first request and bits 31:16 on the second, and its slot is freed only after the second. Receive takes bits 15:0 of the first sample as left and bits 15:0 of the second sample as right, and stores the word {right, left}.
- R11: A busy flag is high whenever its queue holds at least one word.
- R12: After reset both queues are empty (`txFree` 16, `rxFill` 0), both error flags are low, `txReady` is high and `rxReady` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| fmtSel | input | 3 | Sample format selector |
| txLevel | input | 2 | Transmit attention level code |
| rxLevel | input | 2 | Receive attention level code |
| txReqEn | input | 1 | Transmit service request enable |
| rxReqEn | input | 1 | Receive service request enable |
| txErrIntEn | input | 1 | Transmit error interrupt enable |
| rxErrIntEn | input | 1 | Receive error interrupt enable |
| txClear | input | 1 | Empty the transmit queue (pulse) |
| rxClear | input | 1 | Empty the receive queue (pulse) |
| txErrClr | input | 1 | Clear the transmit error flag (pulse) |
| rxErrClr | input | 1 | Clear the receive error flag (pulse) |
| busWrValid | input | 1 | Bus word write strobe |
| busWrData | input | 32 | Bus word to transmit |
| busRdReq | input | 1 | Bus word read strobe |
| busRdData | output | 32 | Oldest received word |
| engTxReq | input | 1 | Engine asks for the next transmit sample |
| engTxSample | output | 32 | Current transmit sample |
| engRxValid | input | 1 | Engine delivers a received sample |
| engRxSample | input | 32 | Received sample |
| txFree | output | 6 | Free transmit slots |
| rxFill | output | 6 | Filled receive slots |
| txReady | output | 1 | Transmit attention met |
| rxReady | output | 1 | Receive attention met |
| txBusy | output | 1 | Transmit queue non-empty |
| rxBusy | output | 1 | Receive queue non-empty |
| txErr | output | 1 | Sticky transmit underflow flag |
| rxErr | output | 1 | Sticky receive overflow flag |
| txDrq | output | 1 | Transmit service request |
| rxDrq | output | 1 | Receive service request |
| txErrIrq | output | 1 | Transmit error interrupt |
| rxErrIrq | output | 1 | Receive error interrupt |

## Verification
The assertions assume three things about the inputs. The clear and error-clear inputs are pulses. The format selector does not change while either queue holds data or a paired half is pending. A read or request may arrive in any cycle, including when its queue is empty. The stimulus changes the format only after a queue has been drained or cleared, and it deliberately drives requests into an empty transmit queue and samples into a full receive queue. The bench uses those cases to exercise underflow, overflow, the sticky error flags and the rule that a set wins over a clear in the same cycle.

// File: rtl/afifo_pkg.sv
package afifo_pkg;

  localparam logic [2:0] FMT_L16  = 3'd0;
  localparam logic [2:0] FMT_L20  = 3'd1;
  localparam logic [2:0] FMT_L24  = 3'd2;
  localparam logic [2:0] FMT_FULL = 3'd3;
  localparam logic [2:0] FMT_PAIR = 3'd7;

  // Per-cycle commands from control to datapath
  typedef struct packed {
    logic txPush;
    logic txPop;
    logic txFlush;
    logic rxPush;
    logic rxStage;
    logic rxPop;
    logic rxFlush;
  } fifoStrobes_t;

  // Attention code to slot count: 0->1, 1->4, 2->8, 3->12
  function automatic int attnSlots(input logic [1:0] lvl);
    return (lvl == 2'd0) ? 1 : 4 * int'(lvl);
  endfunction

  // Number of sample bits kept for an LSB-aligned format
  function automatic int keepBits(input logic [2:0] fmt, input int wordW);
    case (fmt)
      FMT_L16: return 16;
      FMT_L20: return 20;
      FMT_L24: return 24;
      default: return wordW;
    endcase
  endfunction

endpackage

// File: rtl/afifo_ring.sv
module afifo_ring #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [WORD_W-1:0] wrData,
  output logic [WORD_W-1:0] rdData,
  output logic [CNT_W-1:0]  used
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
      used  <= '0;
    end else begin
      if (push) wrPtr <= (wrPtr == LAST) ? '0 : wrPtr + 1'b1;
      if (pop)  rdPtr <= (rdPtr == LAST) ? '0 : rdPtr + 1'b1;
      used <= used + {{(CNT_W-1){1'b0}}, push} - {{(CNT_W-1){1'b0}}, pop};
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) mem[wrPtr] <= wrData;
  end

  assign rdData = mem[rdPtr];

endmodule

// File: rtl/afifo_datapath.sv
module afifo_datapath import afifo_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  fifoStrobes_t      strb,
  input  logic [2:0]        fmtSel,
  input  logic              txHalf,
  input  logic [WORD_W-1:0] busWrData,
  input  logic [WORD_W-1:0] engRxSample,
  output logic [CNT_W-1:0]  txUsed,
  output logic [CNT_W-1:0]  rxUsed,
  output logic [WORD_W-1:0] engTxSample,
  output logic [WORD_W-1:0] busRdData
);

  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] keepMask;
  logic [WORD_W-1:0] txHead, rxHead, rxWord;
  logic [HALF_W-1:0] leftHold;
  logic              paired;

  assign paired = (fmtSel == FMT_PAIR);

  always_comb begin
    for (int i = 0; i < WORD_W; i++) keepMask[i] = (i < keepBits(fmtSel, WORD_W));
  end

  // Left half of a paired receive word waits here for its partner
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             leftHold <= '0;
    else if (strb.rxFlush) leftHold <= '0;
    else if (strb.rxStage) leftHold <= engRxSample[HALF_W-1:0];
  end

  assign rxWord = paired ? {engRxSample[HALF_W-1:0], leftHold}
                         : (engRxSample & keepMask);

  afifo_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) uTxRing (
    .clk(clk), .rstN(rstN),
    .push(strb.txPush), .pop(strb.txPop), .flush(strb.txFlush),
    .wrData(busWrData), .rdData(txHead), .used(txUsed)
  );

  afifo_ring #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) uRxRing (
    .clk(clk), .rstN(rstN),
    .push(strb.rxPush), .pop(strb.rxPop), .flush(strb.rxFlush),
    .wrData(rxWord), .rdData(rxHead), .used(rxUsed)
  );

  always_comb begin
    if (txUsed == '0)
      engTxSample = '0;
    else if (paired)
      engTxSample = {{(WORD_W-HALF_W){1'b0}},
                     txHalf ? txHead[WORD_W-1:HALF_W] : txHead[HALF_W-1:0]};
    else
      engTxSample = txHead & keepMask;
  end

  assign busRdData = (rxUsed == '0) ? '0 : rxHead;

endmodule

// File: rtl/afifo_ctrl.sv
module afifo_ctrl import afifo_pkg::*; #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [2:0]       fmtSel,
  input  logic [1:0]       txLevel,
  input  logic [1:0]       rxLevel,
  input  logic             txReqEn,
  input  logic             rxReqEn,
  input  logic             txErrIntEn,
  input  logic             rxErrIntEn,
  input  logic             txClear,
  input  logic             rxClear,
  input  logic             txErrClr,
  input  logic             rxErrClr,
  input  logic             busWrValid,
  input  logic             busRdReq,
  input  logic             engTxReq,
  input  logic             engRxValid,
  input  logic [CNT_W-1:0] txUsed,
  input  logic [CNT_W-1:0] rxUsed,
  output fifoStrobes_t     strb,
  output logic             txHalf,
  output logic [CNT_W-1:0] txFree,
  output logic             txReady,
  output logic             rxReady,
  output logic             txBusy,
  output logic             rxBusy,
  output logic             txErr,
  output logic             rxErr,
  output logic             txDrq,
  output logic             rxDrq,
  output logic             txErrIrq,
  output logic             rxErrIrq
);

  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic paired, txEmpty, txFull, rxEmpty, rxFull;
  logic rxHalf, txUnder, rxDone, rxOver;

  assign paired  = (fmtSel == FMT_PAIR);
  assign txEmpty = (txUsed == '0);
  assign txFull  = (txUsed == FULL_CNT);
  assign rxEmpty = (rxUsed == '0);
  assign rxFull  = (rxUsed == FULL_CNT);

  assign txUnder = engTxReq && txEmpty && !txClear;
  assign rxDone  = engRxValid && !rxClear && (!paired || rxHalf);
  assign rxOver  = rxDone && rxFull;

  always_comb begin
    strb         = '0;
    strb.txFlush = txClear;
    strb.txPush  = busWrValid && !txFull && !txClear;
    strb.txPop   = engTxReq && !txEmpty && !txClear && (!paired || txHalf);
    strb.rxFlush = rxClear;
    strb.rxStage = engRxValid && !rxClear && paired && !rxHalf;
    strb.rxPush  = rxDone && !rxFull;
    strb.rxPop   = busRdReq && !rxEmpty && !rxClear;
  end

  // Paired-mode half trackers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                      txHalf <= 1'b0;
    else if (txClear)               txHalf <= 1'b0;
    else if (engTxReq && !txEmpty)  txHalf <= paired ? !txHalf : 1'b0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           rxHalf <= 1'b0;
    else if (rxClear)    rxHalf <= 1'b0;
    else if (engRxValid) rxHalf <= paired ? !rxHalf : 1'b0;
  end

  // Sticky errors: a new event wins over a clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txErr <= 1'b0;
      rxErr <= 1'b0;
    end else begin
      if (txUnder)       txErr <= 1'b1;
      else if (txErrClr) txErr <= 1'b0;
      if (rxOver)        rxErr <= 1'b1;
      else if (rxErrClr) rxErr <= 1'b0;
    end
  end

  assign txFree   = FULL_CNT - txUsed;
  assign txReady  = txFree >= CNT_W'(attnSlots(txLevel));
  assign rxReady  = rxUsed >= CNT_W'(attnSlots(rxLevel));
  assign txBusy   = !txEmpty;
  assign rxBusy   = !rxEmpty;
  assign txDrq    = txReady && txReqEn;
  assign rxDrq    = rxReady && rxReqEn;
  assign txErrIrq = txErr && txErrIntEn;
  assign rxErrIrq = rxErr && rxErrIntEn;

endmodule

// File: rtl/audio_sample_fifo_pair.sv
module audio_sample_fifo_pair import afifo_pkg::*; #(
  parameter int DEPTH  = 16,
  parameter int WORD_W = 32,
  parameter int CNT_W  = 6
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        fmtSel,
  input  logic [1:0]        txLevel,
  input  logic [1:0]        rxLevel,
  input  logic              txReqEn,
  input  logic              rxReqEn,
  input  logic              txErrIntEn,
  input  logic              rxErrIntEn,
  input  logic              txClear,
  input  logic              rxClear,
  input  logic              txErrClr,
  input  logic              rxErrClr,
  input  logic              busWrValid,
  input  logic [WORD_W-1:0] busWrData,
  input  logic              busRdReq,
  output logic [WORD_W-1:0] busRdData,
  input  logic              engTxReq,
  output logic [WORD_W-1:0] engTxSample,
  input  logic              engRxValid,
  input  logic [WORD_W-1:0] engRxSample,
  output logic [CNT_W-1:0]  txFree,
  output logic [CNT_W-1:0]  rxFill,
  output logic              txReady,
  output logic              rxReady,
  output logic              txBusy,
  output logic              rxBusy,
  output logic              txErr,
  output logic              rxErr,
  output logic              txDrq,
  output logic              rxDrq,
  output logic              txErrIrq,
  output logic              rxErrIrq
);

  fifoStrobes_t     strb;
  logic             txHalf;
  logic [CNT_W-1:0] txUsed;

  afifo_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .fmtSel(fmtSel),
    .txLevel(txLevel), .rxLevel(rxLevel),
    .txReqEn(txReqEn), .rxReqEn(rxReqEn),
    .txErrIntEn(txErrIntEn), .rxErrIntEn(rxErrIntEn),
    .txClear(txClear), .rxClear(rxClear),
    .txErrClr(txErrClr), .rxErrClr(rxErrClr),
    .busWrValid(busWrValid), .busRdReq(busRdReq),
    .engTxReq(engTxReq), .engRxValid(engRxValid),
    .txUsed(txUsed), .rxUsed(rxFill),
    .strb(strb), .txHalf(txHalf), .txFree(txFree),
    .txReady(txReady), .rxReady(rxReady),
    .txBusy(txBusy), .rxBusy(rxBusy),
    .txErr(txErr), .rxErr(rxErr),
    .txDrq(txDrq), .rxDrq(rxDrq),
    .txErrIrq(txErrIrq), .rxErrIrq(rxErrIrq)
  );

  afifo_datapath #(.DEPTH(DEPTH), .WORD_W(WORD_W), .CNT_W(CNT_W)) uData (
    .clk(clk), .rstN(rstN), .strb(strb), .fmtSel(fmtSel), .txHalf(txHalf),
    .busWrData(busWrData), .engRxSample(engRxSample),
    .txUsed(txUsed), .rxUsed(rxFill),
    .engTxSample(engTxSample), .busRdData(busRdData)
  );

endmodule

// File: rtl/afifo_checks.sv
module afifo_checks #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 6
) (
  input logic             clk,
  input logic             rstN,
  input logic             txClear,
  input logic             rxClear,
  input logic             txErrClr,
  input logic             busRdReq,
  input logic             engTxReq,
  input logic [CNT_W-1:0] txFree,
  input logic [CNT_W-1:0] rxFill,
  input logic             txErr,
  input logic             rxReady
);

  a_r1_tx_free_bound: assert property (@(posedge clk) disable iff (!rstN)
    txFree <= CNT_W'(DEPTH));

  a_r2_rx_fill_bound: assert property (@(posedge clk) disable iff (!rstN)
    rxFill <= CNT_W'(DEPTH));

  a_r3_rx_ready_needs_data: assert property (@(posedge clk) disable iff (!rstN)
    (rxFill == '0) |-> !rxReady);

  a_r5_tx_underflow: assert property (@(posedge clk) disable iff (!rstN)
    (txFree == CNT_W'(DEPTH) && engTxReq && !txClear) |=> txErr);

  a_r6_rx_full_hold: assert property (@(posedge clk) disable iff (!rstN)
    (rxFill == CNT_W'(DEPTH) && !busRdReq && !rxClear) |=> (rxFill == CNT_W'(DEPTH)));

  a_r7_tx_err_sticky: assert property (@(posedge clk) disable iff (!rstN)
    (txErr && !txErrClr) |=> txErr);

  a_r8_tx_clear: assert property (@(posedge clk) disable iff (!rstN)
    txClear |=> (txFree == CNT_W'(DEPTH)));

  a_r8_rx_clear: assert property (@(posedge clk) disable iff (!rstN)
    rxClear |=> (rxFill == '0));

endmodule

bind audio_sample_fifo_pair afifo_checks #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uChk (.*);

// File: tb/sim_audio_sample_fifo_pair.sv
module sim_audio_sample_fifo_pair;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  fmtSel = 3'd3;
  logic [1:0]  txLevel = '0, rxLevel = '0;
  logic        txReqEn = 0, rxReqEn = 0, txErrIntEn = 0, rxErrIntEn = 0;
  logic        txClear = 0, rxClear = 0, txErrClr = 0, rxErrClr = 0;
  logic        busWrValid = 0, busRdReq = 0, engTxReq = 0, engRxValid = 0;
  logic [31:0] busWrData = '0, engRxSample = '0;
  logic [31:0] busRdData, engTxSample;
  logic [5:0]  txFree, rxFill;
  logic        txReady, rxReady, txBusy, rxBusy, txErr, rxErr;
  logic        txDrq, rxDrq, txErrIrq, rxErrIrq;

  int nChecks = 0;
  int nFail = 0;
  logic [31:0] expTx[$];
  logic [31:0] expRx[$];
  logic        rxHalfB = 0;
  logic [15:0] leftB = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  audio_sample_fifo_pair u0 (.*);

  function automatic logic [31:0] keepLow(input logic [2:0] f, input logic [31:0] w);
    case (f)
      3'd0: return w & 32'h0000_FFFF;
      3'd1: return w & 32'h000F_FFFF;
      3'd2: return w & 32'h00FF_FFFF;
      default: return w;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  // Driver: bus write, expected samples go to the transmit scoreboard
  task automatic wrTx(input logic [31:0] w);
    if (txFree != 0) begin
      if (fmtSel == 3'd7) begin
        expTx.push_back({16'h0, w[15:0]});
        expTx.push_back({16'h0, w[31:16]});
      end else expTx.push_back(keepLow(fmtSel, w));
    end
    busWrValid = 1; busWrData = w;
    step();
    busWrValid = 0;
  endtask

  // Monitor: engine request, compare with scoreboard head
  task automatic popTx(input string tag);
    logic [31:0] e;
    engTxReq = 1;
    #1;
    e = (expTx.size() == 0) ? 32'h0 : expTx.pop_front();
    chk(tag, engTxSample, e);
    step();
    engTxReq = 0;
  endtask

  task automatic pushRx(input logic [31:0] s);
    logic done;
    logic [31:0] w;
    done = 0; w = '0;
    if (fmtSel == 3'd7) begin
      if (!rxHalfB) begin leftB = s[15:0]; rxHalfB = 1; end
      else begin w = {s[15:0], leftB}; done = 1; rxHalfB = 0; end
    end else begin w = keepLow(fmtSel, s); done = 1; end
    if (done && rxFill < 16) expRx.push_back(w);
    engRxValid = 1; engRxSample = s;
    step();
    engRxValid = 0;
  endtask

  task automatic rdRx(input string tag);
    logic [31:0] e;
    busRdReq = 1;
    #1;
    e = (expRx.size() == 0) ? 32'h0 : expRx.pop_front();
    chk(tag, busRdData, e);
    step();
    busRdReq = 0;
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    nFail++;
    $display("FAIL watchdog expired act=%0d exp=%0d", 1, 0);
    summary();
    $finish;
  end

  initial begin
    step(); step();
    // R12 reset state
    chk("R12 txFree", {26'h0, txFree}, 32'd16);
    chk("R12 rxFill", {26'h0, rxFill}, 32'd0);
    chk("R12 errs", {30'h0, txErr, rxErr}, 32'd0);
    chk("R12 ready", {30'h0, txReady, rxReady}, 32'b10);
    rstN = 1;
    step();

    // R1 R3 R11 R4: full-width transmit
    fmtSel = 3'd3; txLevel = 2'd3; txReqEn = 1;
    wrTx(32'hDEAD_BEEF); wrTx(32'h1234_5678); wrTx(32'h0BAD_F00D);
    chk("R1 txFree after 3", {26'h0, txFree}, 32'd13);
    chk("R11 txBusy", {31'h0, txBusy}, 32'd1);
    wrTx(32'hA5A5_5A5A);
    chk("R3 txReady at 12 free", {31'h0, txReady}, 32'd1);
    wrTx(32'hCAFE_0001);
    chk("R3 txReady at 11 free", {31'h0, txReady}, 32'd0);
    chk("R4 txDrq follows ready", {31'h0, txDrq}, 32'd0);
    txLevel = 2'd2; #1;
    chk("R3 level 8 ready", {31'h0, txReady}, 32'd1);
    chk("R4 txDrq high", {31'h0, txDrq}, 32'd1);
    for (int i = 0; i < 5; i++) popTx("R1 R9 tx order");
    chk("R11 txBusy idle", {31'h0, txBusy}, 32'd0);

    // R5 R4 R7 underflow and sticky error
    txErrIntEn = 1;
    popTx("R5 empty sample zero");
    chk("R5 txErr set", {31'h0, txErr}, 32'd1);
    chk("R4 txErrIrq", {31'h0, txErrIrq}, 32'd1);
    step(); step();
    chk("R7 txErr sticky", {31'h0, txErr}, 32'd1);
    txErrClr = 1; step(); txErrClr = 0;
    chk("R7 txErr cleared", {31'h0, txErr}, 32'd0);
    txErrClr = 1; popTx("R7 set-wins sample"); txErrClr = 0;
    chk("R7 set wins over clear", {31'h0, txErr}, 32'd1);
    txErrClr = 1; step(); txErrClr = 0;

    // R1 full and overflow drop
    for (int i = 0; i < 16; i++) wrTx(32'h1000_0000 + i);
    chk("R1 txFree full", {26'h0, txFree}, 32'd0);
    wrTx(32'hFFFF_FFFF);
    chk("R1 drop on full", {26'h0, txFree}, 32'd0);
    for (int i = 0; i < 16; i++) popTx("R1 drain after drop");
    chk("R1 drained", {26'h0, txFree}, 32'd16);

    // R9 LSB-aligned transmit formats
    begin
      logic [2:0] fl[4] = '{3'd0, 3'd1, 3'd2, 3'd5};
      for (int k = 0; k < 4; k++) begin
        fmtSel = fl[k];
        wrTx(32'hABCD_1234);
        popTx("R9 tx format mask");
      end
    end

    // R10 paired transmit
    fmtSel = 3'd7;
    wrTx(32'h2222_1111); wrTx(32'h4444_3333);
    popTx("R10 tx left");
    chk("R10 slot held after left", {26'h0, txFree}, 32'd14);
    popTx("R10 tx right");
    chk("R10 slot freed after right", {26'h0, txFree}, 32'd15);
    popTx("R10 tx left 2"); popTx("R10 tx right 2");

    // R8 clear mid-pair keeps error
    popTx("R8 underflow before clear");
    wrTx(32'h7777_6666); wrTx(32'h8888_9999);
    popTx("R8 left before clear");
    txClear = 1; step(); txClear = 0;
    expTx.delete();
    chk("R8 tx emptied", {26'h0, txFree}, 32'd16);
    chk("R8 txErr untouched", {31'h0, txErr}, 32'd1);
    wrTx(32'h6666_5555);
    popTx("R8 half restarted");
    popTx("R8 right after restart");
    txErrClr = 1; step(); txErrClr = 0;

    // R2 R3 receive, full width
    fmtSel = 3'd3; rxLevel = 2'd0; rxReqEn = 1;
    pushRx(32'h0102_0304);
    chk("R3 rxReady 1 slot", {31'h0, rxReady}, 32'd1);
    chk("R4 rxDrq", {31'h0, rxDrq}, 32'd1);
    rxLevel = 2'd1; #1;
    chk("R3 rxReady level 4 not met", {31'h0, rxReady}, 32'd0);
    pushRx(32'hF0F0_0F0F); pushRx(32'h5555_AAAA); pushRx(32'h9876_5432);
    chk("R3 rxReady level 4 met", {31'h0, rxReady}, 32'd1);
    chk("R2 rxFill", {26'h0, rxFill}, 32'd4);
    for (int i = 0; i < 4; i++) rdRx("R2 rx order");
    rdRx("R2 empty read zero");
    chk("R2 empty read no change", {26'h0, rxFill}, 32'd0);
    chk("R2 empty read no error", {31'h0, rxErr}, 32'd0);

    // R6 overflow
    rxErrIntEn = 1;
    for (int i = 0; i < 16; i++) pushRx(32'h2000_0000 + i);
    pushRx(32'hEEEE_EEEE);
    chk("R6 rxFill stays full", {26'h0, rxFill}, 32'd16);
    chk("R6 rxErr set", {31'h0, rxErr}, 32'd1);
    chk("R4 rxErrIrq", {31'h0, rxErrIrq}, 32'd1);
    for (int i = 0; i < 16; i++) rdRx("R6 contents intact");
    rxErrClr = 1; step(); rxErrClr = 0;
    chk("R7 rxErr cleared", {31'h0, rxErr}, 32'd0);

    // R9 receive mask
    fmtSel = 3'd1;
    pushRx(32'hFFFF_FFFF);
    rdRx("R9 rx 20-bit mask");

    // R10 paired receive
    fmtSel = 3'd7;
    pushRx(32'h0000_AAAA);
    chk("R10 no word after left", {26'h0, rxFill}, 32'd0);
    pushRx(32'h9999_BBBB);
    rdRx("R10 rx pair word");

    // R8 receive clear restarts pairing
    pushRx(32'h0000_1111); pushRx(32'h0000_2222); pushRx(32'h0000_3333);
    rxClear = 1; step(); rxClear = 0;
    expRx.delete(); rxHalfB = 0;
    chk("R8 rx emptied", {26'h0, rxFill}, 32'd0);
    pushRx(32'h0000_4444); pushRx(32'h0000_5555);
    rdRx("R8 rx pair after clear");

    step();
    summary();
    $finish;
  end

endmodule